// File: doc/BRIEF.md
# Grouped Register Write-Protect Unit

This unit sits between a simple register bus and a peripheral's configuration registers. It decides, write by write, whether a register may be updated. The guarded registers fall into six protection groups. An address decoder outside the unit says which group the register at the current write address belongs to. Each group carries two independent locks. The soft lock can be switched on and off by command. The hard lock can only be switched on, and stays on until the unit is reset. A group is protected while either of its locks is on.

Software drives the locks by writing a command code and a group-select mask to a control address. Writes aimed at a protected group are blocked: the write-enable toward the guarded registers stays low, and the unit records a violation together with the word address of the blocked target. A status address returns both lock vectors, the violation flag and the recorded address. Reading the status address clears the violation record. The read and write channels have separate addresses, so a status read and a blocked write can fall in the same cycle.

Top module: `wprot_guard`

## Requirements
- R1: After a synchronous reset, the soft locks, the hard locks, the violation flag and the recorded address all read as zero.
- R2: A control write whose command field wr_data[1:0] is 1 sets the soft lock of every group whose bit is 1 in the mask field wr_data[13:8]. All other groups keep their lock state.
- R3: A control write with command 0 clears the soft lock of every group selected in the mask. Unselected soft locks are unchanged.
- R4: A control write with command 2 sets the hard lock of the selected groups. No command clears a hard lock; only reset does.
- R5: A control write with command 3 changes no lock.
- R6: In the cycle of a write to a non-local address, reg_wr_en is low if tgt_guarded is high and group tgt_group has either lock on; otherwise reg_wr_en follows wr_en. A group index of 6 or 7 names no group and is never protected.
- R7: A blocked write sets the violation flag and stores wr_addr[7:2] as the recorded address, visible from the next cycle.
- R8: A status read returns, in the same cycle, the soft locks in bits [5:0], the hard locks in bits [13:8], the violation flag in bit 16 and the recorded address in bits [29:24]. After a status read with no blocked write in that cycle, the flag and the recorded address are zero. Reads of any other address return zero.
- R9: When a blocked write and a status read happen in the same cycle, the read returns the old record, and afterwards the flag is set and the recorded address is the new one.
- R10: After several blocked writes with no status read between them, the recorded address is that of the most recent one.
- R11: Writes to the control or status address never raise reg_wr_en and never record a violation, whatever the group inputs say. A write to the status address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational in the read cycle |
| tgt_guarded | input | 1 | The register at wr_addr belongs to a protection group |
| tgt_group | input | 3 | Group index of the register at wr_addr |
| reg_wr_en | output | 1 | Write-enable toward the guarded registers |

## Verification
Every cycle, the bound checker checks the write-enable gating against the current lock state, the capture of a blocked address, the clearing after a status read, the stickiness of the hard locks, and the effect of each command code on the lock vectors. Only the bench's scenarios show the status word layout, the old record returned in a read that collides with a new violation, the most-recent-wins rule across several violations, and a reset that clears hard locks already set. The bench's reference model predicts reg_wr_en and rd_data every cycle across all these scenarios.

// File: rtl/wprot_pkg.sv
// Shared definitions for the grouped write-protect unit.
// Assumes a 32-bit bus word; the field positions below fit up to eight
// groups and an eight-bit recorded word address.
package wprot_pkg;

    // Command codes carried in the control word
    typedef enum logic [1:0] {
        CMD_SOFT_CLR = 2'd0,
        CMD_SOFT_SET = 2'd1,
        CMD_HARD_SET = 2'd2,
        CMD_RESERVED = 2'd3
    } lock_cmd_e;

    // Control word layout
    localparam int CMD_LSB  = 0;
    localparam int CMD_W    = 2;
    localparam int MASK_LSB = 8;

    // Status word layout
    localparam int ST_SOFT_LSB = 0;
    localparam int ST_HARD_LSB = 8;
    localparam int ST_FLAG_BIT = 16;
    localparam int ST_SRC_LSB  = 24;

endpackage

// File: rtl/wprot_lock_bank.sv
// Per-group soft and hard lock state.
// A command acts on the groups whose select bit is set. The soft lock is
// set or cleared by command; the hard lock is only set, and only reset
// clears it. Reserved command codes leave every lock as it is.
module wprot_lock_bank
    import wprot_pkg::*;
#(
    parameter int NUM_GROUPS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  lock_cmd_e             cmd,
    input  logic [NUM_GROUPS-1:0] grp_sel,
    output logic [NUM_GROUPS-1:0] soft_lock,
    output logic [NUM_GROUPS-1:0] hard_lock
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic soft_q;
        logic hard_q;

        // Soft lock: set or cleared by command for a selected group
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                soft_q <= 1'b0;
            end else if (cmd_valid && grp_sel[g]) begin
                case (cmd)
                    CMD_SOFT_CLR: soft_q <= 1'b0;
                    CMD_SOFT_SET: soft_q <= 1'b1;
                    default:      soft_q <= soft_q;
                endcase
            end
        end

        // Hard lock: set by command, cleared by reset only
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hard_q <= 1'b0;
            end else if (cmd_valid && grp_sel[g] && (cmd == CMD_HARD_SET)) begin
                hard_q <= 1'b1;
            end
        end

        assign soft_lock[g] = soft_q;
        assign hard_lock[g] = hard_q;
    end

endmodule

// File: rtl/wprot_decode.sv
// Address decode and write gating.
// Separates local writes (control, status) from writes to guarded space,
// looks up the lock state of the target's group and decides whether the
// write passes or is blocked. Purely combinational. Assumes tgt_guarded
// and tgt_group describe the register at wr_addr in the same cycle.
module wprot_decode #(
    parameter int                NUM_GROUPS = 6,
    parameter int                ADDR_W     = 8,
    parameter int                GIDX_W     = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hE4,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'hE8
) (
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic                  tgt_guarded,
    input  logic [GIDX_W-1:0]     tgt_group,
    input  logic [NUM_GROUPS-1:0] grp_locked,
    output logic                  ctrl_wr,
    output logic                  stat_rd,
    output logic                  blocked,
    output logic                  reg_wr_en
);

    logic [NUM_GROUPS-1:0] grp_hit;
    logic                  local_wr;
    logic                  guard_hit;

    // One-hot of the target group; out-of-range indices hit nothing
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            grp_hit[g] = (int'(tgt_group) == g);
        end
    end

    // Classify the write and gate it against the target group's locks
    always_comb begin
        local_wr  = (wr_addr == CTRL_ADDR) || (wr_addr == STAT_ADDR);
        guard_hit = tgt_guarded && (|(grp_hit & grp_locked));
        ctrl_wr   = wr_en && (wr_addr == CTRL_ADDR);
        blocked   = wr_en && !local_wr && guard_hit;
        reg_wr_en = wr_en && !local_wr && !guard_hit;
        stat_rd   = rd_en && (rd_addr == STAT_ADDR);
    end

endmodule

// File: rtl/wprot_viol_rec.sv
// Violation record: a flag and the word address of the latest blocked write.
// A blocked write always wins over a clearing status read in the same cycle.
module wprot_viol_rec #(
    parameter int SRC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blocked,
    input  logic [SRC_W-1:0] blk_word,
    input  logic             stat_rd,
    output logic             viol_flag,
    output logic [SRC_W-1:0] viol_src
);

    // Capture on a blocked write, clear on a status read otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_flag <= 1'b0;
            viol_src  <= '0;
        end else if (blocked) begin
            viol_flag <= 1'b1;
            viol_src  <= blk_word;
        end else if (stat_rd) begin
            viol_flag <= 1'b0;
            viol_src  <= '0;
        end
    end

endmodule

// File: rtl/wprot_guard.sv
// Top of the grouped write-protect unit.
// Decodes the register bus, holds the per-group locks, gates writes toward
// the guarded registers and keeps the violation record. Status read data is
// combinational in the read cycle. Assumes NUM_GROUPS <= 8, ADDR_W - 2 <= 8
// and DATA_W >= 32 so the status and control fields fit.
module wprot_guard
    import wprot_pkg::*;
#(
    parameter int                NUM_GROUPS = 6,
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hE4,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'hE8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         tgt_guarded,
    input  logic [$clog2(NUM_GROUPS)-1:0] tgt_group,
    output logic                         reg_wr_en
);

    localparam int GIDX_W = $clog2(NUM_GROUPS);
    localparam int SRC_W  = ADDR_W - 2;

    logic                  ctrl_wr;
    logic                  stat_rd;
    logic                  blocked;
    logic [NUM_GROUPS-1:0] soft_lock;
    logic [NUM_GROUPS-1:0] hard_lock;
    logic [NUM_GROUPS-1:0] grp_locked;
    logic                  viol_flag;
    logic [SRC_W-1:0]      viol_src;
    lock_cmd_e             cmd;
    logic [NUM_GROUPS-1:0] grp_sel;
    logic                  unused_wdata;

    // Extract the command fields from the write data
    assign cmd          = lock_cmd_e'(wr_data[CMD_LSB +: CMD_W]);
    assign grp_sel      = wr_data[MASK_LSB +: NUM_GROUPS];
    assign unused_wdata = ^{wr_data[DATA_W-1:MASK_LSB+NUM_GROUPS],
                            wr_data[MASK_LSB-1:CMD_LSB+CMD_W]};
    assign grp_locked   = soft_lock | hard_lock;

    wprot_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W),
        .GIDX_W     (GIDX_W),
        .CTRL_ADDR  (CTRL_ADDR),
        .STAT_ADDR  (STAT_ADDR)
    ) u_decode (
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .tgt_guarded (tgt_guarded),
        .tgt_group   (tgt_group),
        .grp_locked  (grp_locked),
        .ctrl_wr     (ctrl_wr),
        .stat_rd     (stat_rd),
        .blocked     (blocked),
        .reg_wr_en   (reg_wr_en)
    );

    wprot_lock_bank #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (ctrl_wr),
        .cmd       (cmd),
        .grp_sel   (grp_sel),
        .soft_lock (soft_lock),
        .hard_lock (hard_lock)
    );

    wprot_viol_rec #(
        .SRC_W (SRC_W)
    ) u_viol (
        .clk       (clk),
        .rst_n     (rst_n),
        .blocked   (blocked),
        .blk_word  (wr_addr[ADDR_W-1:2]),
        .stat_rd   (stat_rd),
        .viol_flag (viol_flag),
        .viol_src  (viol_src)
    );

    // Assemble the status word for a status read; other reads return zero
    always_comb begin
        rd_data = '0;
        if (stat_rd) begin
            rd_data[ST_SOFT_LSB +: NUM_GROUPS] = soft_lock;
            rd_data[ST_HARD_LSB +: NUM_GROUPS] = hard_lock;
            rd_data[ST_FLAG_BIT]               = viol_flag;
            rd_data[ST_SRC_LSB +: SRC_W]       = viol_src;
        end
    end

endmodule

// File: rtl/wprot_guard_chk.sv
// Property checker for wprot_guard, attached by bind below.
// Observes the bus, the gating output and the internal lock and record state.
module wprot_guard_chk #(
    parameter int                NUM_GROUPS = 6,
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hE4,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'hE8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic                          tgt_guarded,
    input logic [$clog2(NUM_GROUPS)-1:0] tgt_group,
    input logic                          reg_wr_en,
    input logic [NUM_GROUPS-1:0]         soft_lock,
    input logic [NUM_GROUPS-1:0]         hard_lock,
    input logic                          viol_flag,
    input logic [ADDR_W-3:0]             viol_src
);

    logic                  tgt_locked;
    logic                  is_local;
    logic                  is_ctrl;
    logic                  is_stat_rd;
    logic                  is_blk;
    logic [1:0]            c_cmd;
    logic [NUM_GROUPS-1:0] c_mask;

    // Observed view of the current bus cycle
    always_comb begin
        tgt_locked = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (int'(tgt_group) == g) tgt_locked = soft_lock[g] | hard_lock[g];
        end
        is_local   = (wr_addr == CTRL_ADDR) || (wr_addr == STAT_ADDR);
        is_ctrl    = wr_en && (wr_addr == CTRL_ADDR);
        is_stat_rd = rd_en && (rd_addr == STAT_ADDR);
        is_blk     = wr_en && !is_local && tgt_guarded && tgt_locked;
        c_cmd      = wr_data[1:0];
        c_mask     = wr_data[8 +: NUM_GROUPS];
    end

    p_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && c_cmd == 2'd1) |=> ((soft_lock & $past(c_mask)) == $past(c_mask)));

    p_sw_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && c_cmd == 2'd0) |=> ((soft_lock & $past(c_mask)) == '0));

    p_hw_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_lock != '0) |=> ((hard_lock & $past(hard_lock)) == $past(hard_lock)));

    p_rsvd_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && c_cmd == 2'd3) |=> ($stable(soft_lock) && $stable(hard_lock)));

    p_blocked_no_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_blk |-> !reg_wr_en);

    p_free_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_local && !(tgt_guarded && tgt_locked)) |-> reg_wr_en);

    p_viol_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_blk |=> (viol_flag && viol_src == $past(wr_addr[ADDR_W-1:2])));

    p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stat_rd && !is_blk) |=> (!viol_flag && viol_src == '0));

    p_local_no_we_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_local) |-> !reg_wr_en);

    p_local_no_viol_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_local && !is_stat_rd) |=> ($stable(viol_flag) && $stable(viol_src)));

endmodule

bind wprot_guard wprot_guard_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CTRL_ADDR  (CTRL_ADDR),
    .STAT_ADDR  (STAT_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .tgt_guarded (tgt_guarded),
    .tgt_group   (tgt_group),
    .reg_wr_en   (reg_wr_en),
    .soft_lock   (soft_lock),
    .hard_lock   (hard_lock),
    .viol_flag   (viol_flag),
    .viol_src    (viol_src)
);

// File: tb/test_wprot_guard.sv
`timescale 1ns/100ps
// Bench for wprot_guard: a behavioural reference model predicts reg_wr_en
// and rd_data every cycle and is compared against the design.
module test_wprot_guard;

    localparam logic [7:0] CTRL = 8'hE4;
    localparam logic [7:0] STAT = 8'hE8;
    localparam int         WDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tgt_guarded = 1'b0;
    logic [2:0]  tgt_group = '0;
    logic        reg_wr_en;

    // Reference model state
    bit [5:0] m_soft;
    bit [5:0] m_hard;
    bit       m_flag;
    int       m_src;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    wprot_guard i_wprot_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .tgt_guarded (tgt_guarded),
        .tgt_group   (tgt_group),
        .reg_wr_en   (reg_wr_en)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive, compare against the model, then advance the model
    task automatic step(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                        input bit re, input logic [7:0] ra,
                        input bit g, input logic [2:0] gi, input string req);
        bit          loc;
        bit          lk;
        bit          blk;
        bit          exp_we;
        logic [31:0] exp_rd;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra; tgt_guarded = g; tgt_group = gi;
        #1;
        loc    = (wa == CTRL) || (wa == STAT);
        lk     = (gi < 6) ? (m_soft[gi] | m_hard[gi]) : 1'b0;
        blk    = we && !loc && g && lk;
        exp_we = we && !loc && !blk;
        exp_rd = 32'h0;
        if (re && ra == STAT) begin
            exp_rd = {2'b00, 6'(m_src), 7'b0, m_flag, 2'b00, m_hard, 2'b00, m_soft};
        end
        check(req, "reg_wr_en", {31'b0, reg_wr_en}, {31'b0, exp_we});
        check(req, "rd_data", rd_data, exp_rd);
        @(posedge clk);
        if (we && wa == CTRL) begin
            case (wd[1:0])
                2'd0: m_soft = m_soft & ~wd[13:8];
                2'd1: m_soft = m_soft | wd[13:8];
                2'd2: m_hard = m_hard | wd[13:8];
                default: ;
            endcase
        end
        if (blk) begin
            m_flag = 1'b1;
            m_src  = int'(wa[7:2]);
        end else if (re && ra == STAT) begin
            m_flag = 1'b0;
            m_src  = 0;
        end
    endtask

    task automatic wr_ctrl(input logic [1:0] cmd, input logic [5:0] mask, input string req);
        step(1'b1, CTRL, {18'b0, mask, 6'b0, cmd}, 1'b0, 8'h00, 1'b0, 3'd0, req);
    endtask

    task automatic wr_reg(input logic [7:0] a, input bit g, input logic [2:0] gi, input string req);
        step(1'b1, a, 32'hA5A5_5A5A, 1'b0, 8'h00, g, gi, req);
    endtask

    task automatic rd_stat(input string req);
        step(1'b0, 8'h00, 32'h0, 1'b1, STAT, 1'b0, 3'd0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; tgt_guarded = 1'b0;
        @(posedge clk);
        @(posedge clk);
        m_soft = '0; m_hard = '0; m_flag = 1'b0; m_src = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        do_reset();
        // R1: everything zero after reset
        rd_stat("R1");
        // R6: unguarded and unlocked guarded writes pass
        wr_reg(8'h10, 1'b0, 3'd0, "R6");
        wr_reg(8'h14, 1'b1, 3'd3, "R6");
        // R2: soft-lock groups 0 and 2
        wr_ctrl(2'd1, 6'b000101, "R2");
        rd_stat("R2");
        // R6/R7: group 0 blocked, group 1 free
        wr_reg(8'h10, 1'b1, 3'd0, "R7");
        wr_reg(8'h18, 1'b1, 3'd1, "R6");
        // R8: status shows the record, second read shows it cleared
        rd_stat("R8");
        rd_stat("R8");
        // R6: out-of-range group index is not protected
        wr_reg(8'h20, 1'b1, 3'd6, "R6");
        wr_reg(8'h20, 1'b1, 3'd7, "R6");
        // R3: clear soft lock of group 0 only
        wr_ctrl(2'd0, 6'b000001, "R3");
        wr_reg(8'h10, 1'b1, 3'd0, "R3");
        wr_reg(8'h1C, 1'b1, 3'd2, "R3");
        rd_stat("R3");
        // R4: hard-lock groups 1 and 5; soft clear of all leaves them
        wr_ctrl(2'd2, 6'b100010, "R4");
        wr_ctrl(2'd0, 6'b111111, "R4");
        wr_reg(8'h30, 1'b1, 3'd5, "R4");
        wr_reg(8'h1C, 1'b1, 3'd2, "R4");
        rd_stat("R4");
        // R5: reserved command changes nothing
        wr_ctrl(2'd3, 6'b111111, "R5");
        rd_stat("R5");
        wr_reg(8'h34, 1'b1, 3'd4, "R5");
        // R10: two blocked writes, latest address kept
        wr_reg(8'h10, 1'b1, 3'd1, "R10");
        wr_reg(8'h2C, 1'b1, 3'd5, "R10");
        rd_stat("R10");
        // R9: blocked write in the same cycle as a status read
        wr_reg(8'h40, 1'b1, 3'd1, "R9");
        step(1'b1, 8'h44, 32'h0, 1'b1, STAT, 1'b1, 3'd5, "R9");
        rd_stat("R9");
        rd_stat("R9");
        // R11: local writes never pass or violate, even with a locked group flagged
        step(1'b1, CTRL, 32'h0000_0003, 1'b0, 8'h00, 1'b1, 3'd1, "R11");
        step(1'b1, STAT, 32'hFFFF_FFFF, 1'b0, 8'h00, 1'b1, 3'd5, "R11");
        rd_stat("R11");
        // R8: reads of non-status addresses return zero
        step(1'b0, 8'h00, 32'h0, 1'b1, CTRL, 1'b0, 3'd0, "R8");
        // R2: soft-set of remaining groups, then R1: reset clears hard locks too
        wr_ctrl(2'd1, 6'b011100, "R2");
        wr_reg(8'h24, 1'b1, 3'd3, "R2");
        rd_stat("R2");
        do_reset();
        rd_stat("R1");
        wr_reg(8'h30, 1'b1, 3'd5, "R1");
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule